// File: doc/BRIEF.md
# 4x4 Residual Reconstructor

This block rebuilds one 4x4 tile of 8-bit pixels from a tile of signed 16-bit transform coefficients and the matching tile of predicted pixels. On the full path the coefficients go through a separable integer inverse transform: a butterfly over each row, then the same butterfly over each column of the row results. A rounding offset enters once, through the DC term. Each result is then shifted down arithmetically and added to the prediction, with the sum clamped to the 8-bit range.

Many tiles carry only a DC value or nothing at all. A per-tile nonzero count and a mode flag (intra or inter) choose one of three paths: the full transform, a flat DC add, or a skip that returns the prediction unchanged. A whole tile is taken in one handshake. The reconstructed pixels leave on a valid/ready stream, one row of four pixels per beat.

Top module: `resid4_recon`

## Requirements
- R1: After synchronous reset `in_ready` is 1 and `out_valid` is 0.
- R2: A tile is taken on a clock edge where `in_valid` and `in_ready` are both 1. In the next cycle `out_valid` is 1 with row 0. `in_ready` stays 0 until the beat for row 3 has been accepted, and is 1 again in the cycle after that.
- R3: Rows leave in order 0,1,2,3. `out_row` carries the index and `out_last` is 1 only on row 3. A row moves on only on an edge where `out_ready` is 1. While `out_ready` is 0, `out_pix` and `out_row` hold steady.
- R4: In inter mode (`in_intra`=0) with count 0, the output equals the prediction, whatever the coefficients are.
- R5: In intra mode with count 0, a nonzero DC coefficient selects the DC add and a zero DC selects the skip.
- R6: In inter mode with count exactly 1 and a nonzero DC, the value (dc+32)>>6 is added to every pixel, computed without wrap, and all AC coefficients are ignored. Count 1 with a zero DC takes the full path.
- R7: Every other case takes the full path. The 1-D butterfly is e0=x0+x2, e1=x0-x2, e2=(x1>>>1)-x3, e3=x1+(x3>>>1), giving outputs e0+e3, e1+e2, e1-e2, e0-e3. It is applied to each row and then to each column of the row results, and output k of column c is pixel (k,c).
- R8: On the full path, 32 is added once to the DC coefficient before the row pass. Each column-pass output is arithmetically shifted right by 6 before it is added to the prediction.
- R9: On every path, prediction plus residual is clamped to 0..255.
- R10: On the full path the rounding add and all butterfly sums wrap at 16 bits signed.
- R11: Layout: coefficient (r,c) is `in_coef[(4r+c)*16 +: 16]` (DC at bits 15:0), prediction (r,c) is `in_pred[(4r+c)*8 +: 8]`, and output column c is `out_pix[c*8 +: 8]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Tile offered |
| in_ready | output | 1 | Block can take a tile |
| in_coef | input | 256 | Sixteen signed 16-bit coefficients |
| in_pred | input | 128 | Sixteen 8-bit predicted pixels |
| in_nnz | input | 5 | Nonzero-coefficient count of the tile |
| in_intra | input | 1 | 1 = intra mode, 0 = inter mode |
| out_valid | output | 1 | Output row present |
| out_ready | input | 1 | Consumer takes the row |
| out_pix | output | 32 | Four reconstructed pixels of one row |
| out_row | output | 2 | Row index of the current beat |
| out_last | output | 1 | Current beat is row 3 |

## Verification
Tiles are built from a DC value, one placed AC value and a spread pattern over a ramp or flat prediction. Skip cases carry live coefficients so that a wrongly chosen transform would show. DC cases carry an AC value that would shift some pixels if it were used, which separates the flat add from the full transform. Full-path tiles with mixed signs, with large positive and large negative values, and with a DC at the 16-bit limit expose a wrong butterfly term, a rounding offset in the wrong place, missing clamps, and the difference between wrapped and widened arithmetic. The edges of the DC rounding (31, 32, -33) and a stalled output stream test the rounding boundary and the hold behaviour.

// File: rtl/recon_pkg.sv
package recon_pkg;

    localparam int COEF_W    = 16;
    localparam int PIX_W     = 8;
    localparam int BLK_N     = 4;
    localparam int NNZ_W     = 5;
    localparam int RND_SHIFT = 6;
    localparam int RND_ADD   = 1 << (RND_SHIFT - 1);
    localparam int RES_W     = COEF_W + 1;
    localparam int SUM_W     = RES_W + 2;
    localparam int ROW_W     = $clog2(BLK_N);
    localparam int PIX_MAX   = (1 << PIX_W) - 1;
    localparam int COEF_BITS = BLK_N * BLK_N * COEF_W;
    localparam int PRED_BITS = BLK_N * BLK_N * PIX_W;

    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [RES_W-1:0]  res_t;
    typedef logic signed [SUM_W-1:0]  sum_t;
    typedef logic [PIX_W-1:0]         pix_t;

    typedef enum logic [1:0] {
        RM_SKIP = 2'd0,
        RM_DC   = 2'd1,
        RM_FULL = 2'd2
    } recon_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } recon_state_e;

    typedef struct packed {
        logic [COEF_BITS-1:0] coef;
        logic [PRED_BITS-1:0] pred;
        recon_mode_e          mode;
    } recon_job_t;

    // flat DC residual: rounded and scaled without 16-bit wrap
    function automatic res_t dc_term(input coef_t dc);
        res_t s;
        s = res_t'(dc) + res_t'(RND_ADD);
        return s >>> RND_SHIFT;
    endfunction

    // choose the residual that feeds one pixel adder
    function automatic res_t pick_res(input recon_mode_e m, input coef_t full, input res_t dcv);
        res_t r;
        case (m)
            RM_FULL: r = res_t'(full >>> RND_SHIFT);
            RM_DC:   r = dcv;
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic pix_t sat_pix(input sum_t v);
        pix_t p;
        if (v < 0)
            p = '0;
        else if (v > sum_t'(PIX_MAX))
            p = pix_t'(PIX_MAX);
        else
            p = v[PIX_W-1:0];
        return p;
    endfunction

endpackage

// File: rtl/recon_bfly.sv
module recon_bfly
    import recon_pkg::*;
(
    input  coef_t x_i [BLK_N],
    output coef_t y_o [BLK_N]
);
    coef_t ev0, ev1, od0, od1;

    always_comb begin
        ev0 = x_i[0] + x_i[2];
        ev1 = x_i[0] - x_i[2];
        od0 = (x_i[1] >>> 1) - x_i[3];
        od1 = x_i[1] + (x_i[3] >>> 1);
        y_o[0] = ev0 + od1;
        y_o[1] = ev1 + od0;
        y_o[2] = ev1 - od0;
        y_o[3] = ev0 - od1;
    end
endmodule

// File: rtl/recon_sat_add.sv
module recon_sat_add
    import recon_pkg::*;
(
    input  res_t res_i,
    input  pix_t pred_i,
    output pix_t pix_o
);
    sum_t sum;

    always_comb begin
        sum   = {{(SUM_W-RES_W){res_i[RES_W-1]}}, res_i} + {{(SUM_W-PIX_W){1'b0}}, pred_i};
        pix_o = sat_pix(sum);
    end
endmodule

// File: rtl/recon_mode_sel.sv
module recon_mode_sel
    import recon_pkg::*;
(
    input  logic [NNZ_W-1:0] nnz_i,
    input  logic             intra_i,
    input  coef_t            dc_i,
    output recon_mode_e      mode_o
);
    logic dc_nz;

    always_comb begin
        dc_nz = (dc_i != '0);
        if (nnz_i == '0)
            mode_o = (intra_i && dc_nz) ? RM_DC : RM_SKIP;
        else if (!intra_i && nnz_i == NNZ_W'(1) && dc_nz)
            mode_o = RM_DC;
        else
            mode_o = RM_FULL;
    end
endmodule

// File: rtl/resid4_recon.sv
module resid4_recon
    import recon_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [COEF_BITS-1:0] in_coef,
    input  logic [PRED_BITS-1:0] in_pred,
    input  logic [NNZ_W-1:0]     in_nnz,
    input  logic                 in_intra,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [BLK_N*PIX_W-1:0] out_pix,
    output logic [ROW_W-1:0]     out_row,
    output logic                 out_last
);
    recon_mode_e  mode_d;
    recon_job_t   job_q;
    recon_state_e state_q;
    logic [ROW_W-1:0] row_q;

    recon_mode_sel u_sel (
        .nnz_i   (in_nnz),
        .intra_i (in_intra),
        .dc_i    (coef_t'(in_coef[COEF_W-1:0])),
        .mode_o  (mode_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            row_q   <= '0;
            job_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (in_valid) begin
                        job_q   <= '{coef: in_coef, pred: in_pred, mode: mode_d};
                        row_q   <= '0;
                        state_q <= ST_SEND;
                    end
                end
                default: begin
                    if (out_ready) begin
                        if (row_q == ROW_W'(BLK_N-1))
                            state_q <= ST_IDLE;
                        else
                            row_q <= row_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign in_ready  = (state_q == ST_IDLE);
    assign out_valid = (state_q == ST_SEND);
    assign out_row   = row_q;
    assign out_last  = out_valid && (row_q == ROW_W'(BLK_N-1));

    // coefficient matrix with rounding injected through the DC term
    coef_t cm    [BLK_N][BLK_N];
    coef_t rowp  [BLK_N][BLK_N];
    coef_t colin [BLK_N][BLK_N];
    coef_t colp  [BLK_N][BLK_N];
    res_t  res   [BLK_N][BLK_N];
    pix_t  pixm  [BLK_N][BLK_N];
    res_t  dc_res;

    assign dc_res = dc_term(coef_t'(job_q.coef[COEF_W-1:0]));

    for (genvar r = 0; r < BLK_N; r++) begin : g_r
        for (genvar c = 0; c < BLK_N; c++) begin : g_c
            if (r == 0 && c == 0) begin : g_dc
                assign cm[r][c] = coef_t'(job_q.coef[COEF_W-1:0]) + coef_t'(RND_ADD);
            end else begin : g_ac
                assign cm[r][c] = coef_t'(job_q.coef[(r*BLK_N+c)*COEF_W +: COEF_W]);
            end
            assign colin[c][r] = rowp[r][c];
            assign res[r][c]   = pick_res(job_q.mode, colp[c][r], dc_res);

            recon_sat_add u_add (
                .res_i  (res[r][c]),
                .pred_i (job_q.pred[(r*BLK_N+c)*PIX_W +: PIX_W]),
                .pix_o  (pixm[r][c])
            );
        end

        recon_bfly u_rowpass (
            .x_i (cm[r]),
            .y_o (rowp[r])
        );

        recon_bfly u_colpass (
            .x_i (colin[r]),
            .y_o (colp[r])
        );
    end

    for (genvar c = 0; c < BLK_N; c++) begin : g_out
        assign out_pix[c*PIX_W +: PIX_W] = pixm[row_q][c];
    end
endmodule

// File: rtl/resid4_recon_chk.sv
module resid4_recon_chk
    import recon_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic                     in_ready,
    input logic [COEF_W-1:0]        dc_coef,
    input logic [BLK_N*PIX_W-1:0]   pred_row0,
    input logic [NNZ_W-1:0]         in_nnz,
    input logic                     in_intra,
    input logic                     out_valid,
    input logic                     out_ready,
    input logic [BLK_N*PIX_W-1:0]   out_pix,
    input logic [ROW_W-1:0]         out_row,
    input logic                     out_last
);
    // R2
    accept_to_row0_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid && !in_ready && out_row == '0);

    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_pix) && $stable(out_row));

    // R3
    row_step_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && !out_last |=> out_valid && out_row == ROW_W'($past(out_row) + 1'b1));

    // R2
    drain_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && out_last |=> in_ready && !out_valid);

    // R4
    inter_skip_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && in_nnz == '0 && !in_intra |=> out_pix == $past(pred_row0));

    // R5
    intra_skip_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && in_nnz == '0 && in_intra && dc_coef == '0 |=> out_pix == $past(pred_row0));
endmodule

bind resid4_recon resid4_recon_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .dc_coef   (in_coef[COEF_W-1:0]),
    .pred_row0 (in_pred[BLK_N*PIX_W-1:0]),
    .in_nnz    (in_nnz),
    .in_intra  (in_intra),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pix   (out_pix),
    .out_row   (out_row),
    .out_last  (out_last)
);

// File: tb/test_resid4_recon.sv
`timescale 1ns/1ps
module test_resid4_recon;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         in_ready;
    logic [255:0] in_coef;
    logic [127:0] in_pred;
    logic [4:0]   in_nnz;
    logic         in_intra;
    logic         out_valid;
    logic         out_ready;
    logic [31:0]  out_pix;
    logic [1:0]   out_row;
    logic         out_last;

    always #2.5 clk = ~clk;

    resid4_recon i_resid4_recon (.*);

    int n_run = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // independent reference built from the requirements
    function automatic void bf(input shortint x0, input shortint x1, input shortint x2, input shortint x3,
                               output shortint y0, output shortint y1, output shortint y2, output shortint y3);
        shortint a, b, p, q;
        a = x0 + x2;
        b = x0 - x2;
        p = (x1 >>> 1) - x3;
        q = x1 + (x3 >>> 1);
        y0 = a + q;
        y1 = b + p;
        y2 = b - p;
        y3 = a - q;
    endfunction

    function automatic logic [127:0] model(input logic [255:0] cf, input logic [127:0] pd,
                                           input int nnz, input bit intra);
        shortint m [4][4];
        shortint t [4][4];
        shortint z [4][4];
        shortint dc;
        int mode;
        int rv;
        int s;
        logic [127:0] o;
        dc = cf[15:0];
        if (nnz == 0) mode = (intra && dc != 0) ? 1 : 0;
        else if (!intra && nnz == 1 && dc != 0) mode = 1;
        else mode = 2;
        for (int i = 0; i < 16; i++) m[i/4][i%4] = cf[i*16 +: 16];
        m[0][0] = m[0][0] + 16'sd32;
        for (int r = 0; r < 4; r++)
            bf(m[r][0], m[r][1], m[r][2], m[r][3], t[r][0], t[r][1], t[r][2], t[r][3]);
        for (int c = 0; c < 4; c++)
            bf(t[0][c], t[1][c], t[2][c], t[3][c], z[0][c], z[1][c], z[2][c], z[3][c]);
        for (int i = 0; i < 16; i++) begin
            if (mode == 0) rv = 0;
            else if (mode == 1) rv = (int'(dc) + 32) >>> 6;
            else rv = int'(z[i/4][i%4] >>> 6);
            s = int'(pd[i*8 +: 8]) + rv;
            if (s < 0) s = 0;
            if (s > 255) s = 255;
            o[i*8 +: 8] = s[7:0];
        end
        return o;
    endfunction

    typedef struct packed {
        int dc; int ac; int ac_pos; int spread; int base; int step; int nnz; bit intra;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VT [NV] = '{
        '{0,     0,     1, 0,    10,  3, 0, 1'b0},  // R4 plain skip
        '{640,   100,   5, 0,    20,  5, 0, 1'b0},  // R4 skip with live coefficients
        '{640,   0,     1, 0,    20,  5, 0, 1'b1},  // R5 intra DC add (+10)
        '{-100,  500,   5, 0,    100, 1, 1, 1'b0},  // R6 DC add (-2), AC ignored
        '{0,     64,    1, 0,    50,  2, 1, 1'b0},  // R6 zero DC with count 1 -> full, R7
        '{300,   -200,  6, 40,   128, 0, 9, 1'b0},  // R7 R8 mixed signs
        '{4000,  2000,  4, 300,  250, 0, 7, 1'b1},  // R9 clamp high, R7
        '{-4000, -1500, 2, -250, 5,   0, 7, 1'b1},  // R9 clamp low, R7
        '{0,     0,     1, 0,    77,  7, 0, 1'b1},  // R5 intra zero DC skip
        '{640,   0,     1, 0,    30,  1, 2, 1'b0},  // R7 DC-only data but count 2
        '{31,    0,     1, 0,    60,  3, 1, 1'b0},  // R6 rounding edge -> 0
        '{-33,   0,     1, 0,    0,  16, 1, 1'b0},  // R6 R9 -1 with low clamp
        '{32767, 0,     1, 0,    200, 1, 1, 1'b0},  // R6 no wrap, clamp 255
        '{32767, 0,     1, 0,    200, 1, 3, 1'b0}   // R10 full-path wrap
    };

    function automatic logic [255:0] mk_coef(input vec_t v);
        logic [255:0] cf;
        int x;
        for (int i = 0; i < 16; i++) begin
            if (i == 0) x = v.dc;
            else if (i == v.ac_pos) x = v.ac;
            else if (v.spread != 0 && i % 3 == 0) x = (i % 2 == 1) ? v.spread : -v.spread;
            else x = 0;
            cf[i*16 +: 16] = x[15:0];
        end
        return cf;
    endfunction

    function automatic logic [127:0] mk_pred(input vec_t v);
        logic [127:0] pd;
        int x;
        for (int i = 0; i < 16; i++) begin
            x = v.base + v.step * i;
            pd[i*8 +: 8] = x[7:0];
        end
        return pd;
    endfunction

    // offer a tile; optionally stall the output stream for some cycles
    task automatic run_tile(input vec_t v, input int stall, input string req);
        logic [127:0] exp;
        exp = model(mk_coef(v), mk_pred(v), v.nnz, v.intra);
        @(negedge clk);
        in_coef  = mk_coef(v);
        in_pred  = mk_pred(v);
        in_nnz   = v.nnz[4:0];
        in_intra = v.intra;
        in_valid = 1'b1;
        out_ready = (stall == 0);
        check(in_ready == 1'b1, "R2", "in_ready before accept", {31'd0, in_ready}, 32'd1);
        @(negedge clk);
        in_valid = 1'b0;
        for (int k = 0; k < stall; k++) begin
            check(out_valid && out_row == 2'd0 && out_pix == exp[31:0], "R3", "stalled row 0",
                  out_pix, exp[31:0]);
            @(negedge clk);
        end
        out_ready = 1'b1;
        for (int r = 0; r < 4; r++) begin
            check(out_valid == 1'b1 && in_ready == 1'b0, "R2", "busy during output",
                  {30'd0, out_valid, in_ready}, 32'd2);
            check(out_row == 2'(r) && out_last == (r == 3), "R3", "row index/last",
                  {29'd0, out_last, out_row}, {29'd0, (r == 3), 2'(r)});
            check(out_pix == exp[r*32 +: 32], req, "row pixels", out_pix, exp[r*32 +: 32]);
            @(negedge clk);
        end
        check(in_ready == 1'b1 && out_valid == 1'b0, "R2", "idle after row 3",
              {30'd0, in_ready, out_valid}, 32'd2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        in_valid = 1'b0;
        in_coef = '0;
        in_pred = '0;
        in_nnz = '0;
        in_intra = 1'b0;
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(in_ready == 1'b1 && out_valid == 1'b0, "R1", "reset state",
              {30'd0, in_ready, out_valid}, 32'd2);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready == 1'b1 && out_valid == 1'b0, "R1", "idle after reset",
              {30'd0, in_ready, out_valid}, 32'd2);

        for (int i = 0; i < NV; i++) run_tile(VT[i], 0, $sformatf("R%0d", (i < 2) ? 4 : 7));

        // R3 stall on a full-path tile, R8 rounding through the DC term
        run_tile(VT[5], 3, "R8");
        // R6 DC add at the rounding step (32 -> +1), stalled
        run_tile('{32, 0, 1, 0, 90, 2, 1, 1'b0}, 2, "R6");
        // R11 single AC at column 1 of row 0 places its pattern per layout
        run_tile('{0, 640, 1, 0, 128, 0, 1, 1'b1}, 0, "R11");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule